// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block turns an asynchronous serial line back into characters. The line rests high. A character opens with a low start bit, then carries 5 to 8 data bits with the least significant bit first. An optional parity bit follows the data, and one or two high stop bits close the character. The host sets the character shape at runtime through four plain configuration pins. That shape must not change while a character is arriving. A clock enable pulsing at sixteen times the baud rate paces all sampling. The serial input passes through a reset-to-high synchronizer before any decision is made.

The first low sample starts a candidate start bit, which is checked again at its midpoint. The engine then samples every later bit sixteen ticks apart. When the last stop bit has been sampled, the character and its parity, framing and break flags go into a one-entry output register. The host reads that register through a valid/ready handshake. The output is never dropped for back-pressure. `out_valid` stays high and the character and flags stay unchanged until a cycle in which `out_valid` and `out_ready` are both high, or until a newer character replaces the held one. A replacement sets the overrun flag on the newer character.

Top module: `serial_char_rx`

## Requirements
- R1: After reset `out_valid` is 0. While the line stays high, no character is produced.
- R2: A low sample on an enabled tick is rechecked eight ticks later. If the line is high by then, the receiver returns to waiting for a start bit and produces nothing.
- R3: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. The received value sits in the low bits of `out_data`, and all unused upper bits are 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity, where data and parity together hold an even number of ones. `cfg_par_odd`=1 selects odd parity. On a mismatch `out_err_parity` is 1 for that character. With parity disabled the flag is 0.
- R5: `cfg_two_stop` selects two stop bits when 1 and one stop bit when 0. `out_err_frame` is 1 when any stop bit is sampled low.
- R6: If the start, data, parity and stop samples are all low, the character is delivered with data 0 and with both `out_err_break` and `out_err_frame` set. No new character starts until the line has been seen high again.
- R7: Once `out_valid` is 1, it stays 1 with `out_data` and the error flags unchanged until a cycle with `out_ready` high. Unless a new character completes in that same cycle, `out_valid` then drops.
- R8: If a character completes while the previous one is still held and is not being accepted in that cycle, the new character replaces it with `out_err_overrun`=1. A character that completes into an empty register carries `out_err_overrun`=0.
- R9: Sampling advances only on cycles where `tick16` is 1. Spacing the ticks several clocks apart gives the same characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code, length = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| out_valid | output | 1 | A received character is held |
| out_ready | input | 1 | Host accepts the held character |
| out_data | output | 8 | Received character, right-aligned |
| out_err_parity | output | 1 | Parity mismatch on the held character |
| out_err_frame | output | 1 | A stop bit was sampled low |
| out_err_break | output | 1 | The entire character was low |
| out_err_overrun | output | 1 | The held character replaced an unread one |

## Verification
Some rules are checked on every cycle. These are the handshake hold rule, the overrun marking when a character lands on an unread one, the zero upper bits of each completed character, the break flag implying a framing error, and the rule that `out_valid` rises only after a completed character. Other behaviour can only be shown by the bench's scenarios. That includes bit order and data value for every length, parity and stop combination, and the flagging of injected parity and stop faults. It also includes rejection of a short start glitch, the wait for the line to go high after a break, and unchanged results when the ticks are spaced out.

// File: rtl/sci_rx_pkg.sv
`timescale 1ns/1ps
package sci_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
  } rx_flags_t;

endpackage

// File: rtl/sci_rx_sync.sv
`timescale 1ns/1ps
module sci_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sci_rx_engine.sv
`timescale 1ns/1ps
module sci_rx_engine
  import sci_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 2,
  parameter int MIN_LEN    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output rx_flags_t         done_flags
);

  localparam int CNT_W     = $clog2(OVERSAMPLE);
  localparam int POS_W     = $clog2(DATA_W + 1);
  localparam int HALF_LAST = OVERSAMPLE / 2 - 1;
  localparam int FULL_LAST = OVERSAMPLE - 1;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [POS_W-1:0]  bitpos;
  logic [POS_W-1:0]  n_bits;
  logic [DATA_W-1:0] shreg;
  logic              all_zero;
  logic              stop_bad;
  logic              par_bit;
  logic              sample_pt;
  logic              final_zero;
  logic              exp_par;

  // effective length, clamped to the register width
  always_comb begin
    if ((MIN_LEN + int'(cfg_len)) > DATA_W) n_bits = POS_W'(DATA_W);
    else                                     n_bits = POS_W'(MIN_LEN + int'(cfg_len));
  end

  always_comb begin
    if (state == ST_START) sample_pt = tick && (cnt == CNT_W'(HALF_LAST));
    else                   sample_pt = tick && (cnt == CNT_W'(FULL_LAST));
  end

  assign done = sample_pt &&
                (((state == ST_STOP1) && !cfg_two_stop) || (state == ST_STOP2));

  assign final_zero = all_zero && !rx;
  assign done_data  = shreg >> (POS_W'(DATA_W) - n_bits);
  assign exp_par    = (^done_data) ^ cfg_par_odd;

  always_comb begin
    done_flags.perr = cfg_par_en && (par_bit != exp_par);
    done_flags.ferr = stop_bad || !rx;
    done_flags.brk  = final_zero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitpos   <= '0;
      shreg    <= '0;
      all_zero <= 1'b1;
      stop_bad <= 1'b0;
      par_bit  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tick && !rx) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (sample_pt) begin
            cnt <= '0;
            if (rx) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_DATA;
              bitpos   <= '0;
              shreg    <= '0;
              all_zero <= 1'b1;
              stop_bad <= 1'b0;
              par_bit  <= 1'b0;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA, ST_PAR, ST_STOP1, ST_STOP2: begin
          if (sample_pt) cnt <= '0;
          else if (tick) cnt <= cnt + 1'b1;
          if (sample_pt) begin
            all_zero <= all_zero && !rx;
            case (state)
              ST_DATA: begin
                shreg <= {rx, shreg[DATA_W-1:1]};
                if (bitpos == n_bits - 1'b1) state <= cfg_par_en ? ST_PAR : ST_STOP1;
                else                         bitpos <= bitpos + 1'b1;
              end
              ST_PAR: begin
                par_bit <= rx;
                state   <= ST_STOP1;
              end
              ST_STOP1: begin
                stop_bad <= !rx;
                if (cfg_two_stop) state <= ST_STOP2;
                else              state <= final_zero ? ST_HOLD : ST_IDLE;
              end
              default: begin
                stop_bad <= stop_bad || !rx;
                state    <= final_zero ? ST_HOLD : ST_IDLE;
              end
            endcase
          end
        end
        ST_HOLD: begin
          if (rx) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sci_rx_hold.sv
`timescale 1ns/1ps
module sci_rx_hold
  import sci_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_push,
  input  logic [DATA_W-1:0] in_data,
  input  rx_flags_t         in_flags,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output rx_flags_t         out_flags,
  output logic              out_overrun
);

  logic taking;
  assign taking = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_flags   <= '0;
      out_overrun <= 1'b0;
    end else if (in_push) begin
      out_valid   <= 1'b1;
      out_data    <= in_data;
      out_flags   <= in_flags;
      out_overrun <= out_valid && !taking;
    end else if (taking) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_char_rx.sv
`timescale 1ns/1ps
module serial_char_rx
  import sci_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 2,
  parameter int MIN_LEN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err_parity,
  output logic              out_err_frame,
  output logic              out_err_break,
  output logic              out_err_overrun
);

  logic              rx_s;
  logic              eng_done;
  logic [DATA_W-1:0] eng_data;
  rx_flags_t         eng_flags;
  rx_flags_t         held_flags;

  sci_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_s)
  );

  sci_rx_engine #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .MIN_LEN   (MIN_LEN)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick16),
    .rx          (rx_s),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_two_stop(cfg_two_stop),
    .done        (eng_done),
    .done_data   (eng_data),
    .done_flags  (eng_flags)
  );

  sci_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_push    (eng_done),
    .in_data    (eng_data),
    .in_flags   (eng_flags),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_flags  (held_flags),
    .out_overrun(out_err_overrun)
  );

  assign out_err_parity = held_flags.perr;
  assign out_err_frame  = held_flags.ferr;
  assign out_err_break  = held_flags.brk;

endmodule

// File: rtl/sci_rx_checker.sv
`timescale 1ns/1ps
module sci_rx_checker #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_err_parity,
  input logic              out_err_frame,
  input logic              out_err_break,
  input logic              out_err_overrun,
  input logic              eng_done,
  input logic [DATA_W-1:0] eng_data,
  input logic [LEN_W-1:0]  cfg_len
);

  logic [2*DATA_W-1:0] wide_data;
  assign wide_data = {{DATA_W{1'b0}}, eng_data} >> (MIN_LEN + int'(cfg_len));

  // R1
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(eng_done));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (wide_data == '0));

  // R6
  break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err_break) |-> (out_err_frame && (out_data == '0)));

  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !eng_done) |=>
      ($stable(out_data) && $stable(out_err_parity) && $stable(out_err_frame) &&
       $stable(out_err_break) && $stable(out_err_overrun)));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && out_valid && !out_ready) |=> (out_valid && out_err_overrun));

  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !out_valid) |=> !out_err_overrun);

endmodule

bind serial_char_rx sci_rx_checker #(
  .DATA_W (DATA_W),
  .LEN_W  (LEN_W),
  .MIN_LEN(MIN_LEN)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_data       (out_data),
  .out_err_parity (out_err_parity),
  .out_err_frame  (out_err_frame),
  .out_err_break  (out_err_break),
  .out_err_overrun(out_err_overrun),
  .eng_done       (eng_done),
  .eng_data       (eng_data),
  .cfg_len        (cfg_len)
);

// File: tb/serial_char_rx_test.sv
`timescale 1ns/1ps
module serial_char_rx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_err_parity, out_err_frame, out_err_break, out_err_overrun;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_div = 1;
  int tcnt     = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_char_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err_parity(out_err_parity), .out_err_frame(out_err_frame),
    .out_err_break(out_err_break), .out_err_overrun(out_err_overrun)
  );

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin
      tcnt   = 0;
      tick16 = 1'b1;
    end else begin
      tcnt   = tcnt + 1;
      tick16 = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick16) c++;
    end
  endtask

  task automatic line_bits(input logic b, input int nbits);
    @(negedge clk);
    rxd = b;
    wait_ticks(16 * nbits);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit bad_stop);
    int len = 5 + int'(cfg_len);
    logic p = 1'b0;
    line_bits(1'b0, 1);
    for (int i = 0; i < len; i++) begin
      line_bits(d[i], 1);
      p = p ^ d[i];
    end
    if (cfg_par_en) line_bits(p ^ cfg_par_odd ^ flip_par, 1);
    line_bits(!bad_stop, 1);
    if (cfg_two_stop) line_bits(1'b1, 1);
    line_bits(1'b1, 1);
  endtask

  task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe,
                             input bit br, input bit ov, input string req);
    @(negedge clk);
    check(out_valid === 1'b1, req, "valid", {15'd0, out_valid}, 16'd1);
    check(out_data === d && out_err_parity === pe && out_err_frame === fe &&
          out_err_break === br && out_err_overrun === ov, req, "data/flags",
          {4'd0, out_err_parity, out_err_frame, out_err_break, out_err_overrun, out_data},
          {4'd0, pe, fe, br, ov, d});
  endtask

  task automatic accept();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0, "R7", "valid after accept", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] mask;
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and quiet idle line
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "valid after reset", {15'd0, out_valid}, 16'd0);
    wait_ticks(200);
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "valid on idle line", {15'd0, out_valid}, 16'd0);

    // R3 R4 R5: sweep every length, parity mode and stop count
    for (int l = 0; l < 4; l++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int st = 0; st < 2; st++) begin
          cfg_len      = 2'(l);
          cfg_par_en   = (pm != 0);
          cfg_par_odd  = (pm == 2);
          cfg_two_stop = st[0];
          mask = 8'((16'd1 << (5 + l)) - 1);
          for (int k = 0; k < 8; k++) begin
            bit fp = (k == 3) && (pm != 0);
            bit bs = (k == 5);
            if (k == 0)      v = 8'h00;
            else if (k == 1) v = mask;
            else             v = 8'((k * 53 + (l * 6 + pm * 2 + st) * 29 + 7)) & mask;
            send_frame(v | ~mask, fp, bs);
            expect_char(v, fp, bs, 1'b0, 1'b0, "R3 R4 R5");
            if (k == 2) begin
              repeat (20) @(negedge clk);
              check(out_valid === 1'b1 && out_data === v, "R7", "held under back-pressure",
                    {7'd0, out_valid, out_data}, {8'd1, v});
            end
            accept();
          end
        end
      end
    end

    // R2: short low glitch is rejected
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
    @(negedge clk);
    rxd = 1'b0;
    wait_ticks(4);
    @(negedge clk);
    rxd = 1'b1;
    wait_ticks(64);
    @(negedge clk);
    check(out_valid === 1'b0, "R2", "glitch produced output", {15'd0, out_valid}, 16'd0);
    send_frame(8'h3C, 1'b0, 1'b0);
    expect_char(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    accept();

    // R6: break, then wait for the line to rise
    line_bits(1'b0, 14);
    expect_char(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
    accept();
    line_bits(1'b0, 14);
    @(negedge clk);
    check(out_valid === 1'b0, "R6", "no frame while line stays low", {15'd0, out_valid}, 16'd0);
    line_bits(1'b1, 2);
    send_frame(8'h81, 1'b0, 1'b0);
    expect_char(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    accept();

    // R8: second character lands on an unread one
    send_frame(8'h11, 1'b0, 1'b0);
    send_frame(8'hE2, 1'b0, 1'b0);
    expect_char(8'hE2, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    accept();
    send_frame(8'h47, 1'b0, 1'b0);
    expect_char(8'h47, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    accept();

    // R9: sparse ticks give the same result
    tick_div = 3;
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
    send_frame(8'hA5, 1'b0, 1'b0);
    expect_char(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    accept();
    cfg_len = 2'd1;
    send_frame(8'h2B, 1'b1, 1'b0);
    expect_char(8'h2B, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    accept();

    finish_run();
  end

endmodule